// File: doc/BRIEF.md
# Linked-list descriptor DMA channel

This block is one DMA channel that works through a chain of transfer descriptors kept in memory. Software places the address of the first descriptor in the channel's register window and starts the channel. From then on the channel fetches each six-word descriptor by itself, moves the bytes it describes one beat at a time, and follows the next-descriptor pointer until it meets a fixed end-of-chain value. It then stops by itself.

The channel has three memory-side ports. A word-read port fetches descriptors. A read port and a write port move the data. Both data ports take an explicit beat size, and byte lane 0 carries the byte at the addressed location. The channel emits a one-cycle event when each descriptor completes and another when the whole chain completes. The live copy of the current descriptor can be read back through the window, including the number of bytes still to move. Software can pause and resume the channel, and it can stop the channel at any time, including while it is paused.

When either side of a transfer is a fixed-address peripheral port, a single ready input gates each beat. The window sits at byte offset 0x100 + 0x40 × channel index inside the register space. The channel index is a parameter.

Top module: `lldma_chan`

## Requirements
- R1: After reset the enable readback (window +0x00, bit 0 = busy) is 0. The hold readback (+0x04, bit 1) is 0 and the remaining count (+0x18) is 0. No descriptor, read or write request is issued, and no event is raised until software starts the channel.
- R2: Writing 1 in bit 0 of +0x00 starts a walk from the address held at +0x08. The channel fetches six consecutive words in this order: config, source, destination, byte length, parameter, next pointer. The live config, source, destination, count and parameter words read back at +0x0C, +0x10, +0x14, +0x18 and +0x1C.
- R3: When a descriptor whose next pointer equals 0xFFFFF800 completes, queue_done_o pulses for one cycle together with pkg_done_o. The channel then returns to idle, and the enable readback shows 0.
- R4: Each completed descriptor raises pkg_done_o for one cycle. If its next pointer is not the end value, the channel then fetches the descriptor at that pointer.
- R5: The width codes sit in config bits 10:9 (source) and 26:25 (destination), where 0 = 1 byte, 1 = 2 bytes and 2 or 3 = 4 bytes. Each beat moves the smaller of the two widths. A beat is a read at the source followed by a write of the same data at the destination, with the byte at the lowest address in bits 7:0.
- R6: A linear address advances by the beat size after each beat. Fixed-address mode is config bit 5 for the source and bit 21 for the destination. An address in that mode stays the same for every beat.
- R7: The count readback equals the descriptor length minus the bytes written so far in that descriptor.
- R8: While either side is in fixed-address mode, no data read is issued while periph_ready_i is low.
- R9: Writing 1 in bit 1 of +0x04 holds the channel. No new fetch or beat starts, and the count and addresses stay constant. Writing 0 there resumes the channel, and the chain completes normally.
- R10: Writing 0 in bit 0 of +0x00 returns the channel to idle at once, even while it is held. It drops the partial descriptor without further writes or events and clears the hold bit. A later start walks the chain again from the first descriptor.
- R11: The low two bits of the first-descriptor address and of every next pointer are ignored. Descriptor fetches use word-aligned addresses only.
- R12: A descriptor with byte length 0 completes with its pkg_done_o event and moves no data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| desc_req_o | output | 1 | Descriptor word read request |
| desc_addr_o | output | 32 | Descriptor word address |
| desc_rvalid_i | input | 1 | Descriptor word response valid |
| desc_rdata_i | input | 32 | Descriptor word response data |
| xfer_rd_req_o | output | 1 | Data read request |
| xfer_rd_addr_o | output | 32 | Data read address |
| xfer_rd_size_o | output | 2 | Data read size code (0/1/2 = 1/2/4 bytes) |
| xfer_rvalid_i | input | 1 | Data read response valid |
| xfer_rdata_i | input | 32 | Data read response, addressed byte in bits 7:0 |
| xfer_wr_en_o | output | 1 | Data write, accepted in the cycle it is high |
| xfer_wr_addr_o | output | 32 | Data write address |
| xfer_wr_size_o | output | 2 | Data write size code |
| xfer_wr_data_o | output | 32 | Data write data, addressed byte in bits 7:0 |
| periph_ready_i | input | 1 | Peripheral ready for a beat on a fixed-address side |
| pkg_done_o | output | 1 | One-cycle pulse per completed descriptor |
| queue_done_o | output | 1 | One-cycle pulse when the chain ends |

## Verification
The copy function is tried with the following patterns:
- A single 4-byte-wide memory copy.
- A two-descriptor chain with misaligned pointers, 1-byte beats and mixed 4/2-byte widths. This pattern separates beat sizing from address stepping and from pointer alignment.
- A zero-length descriptor.
- A fixed-destination transfer gated by the ready input.

Holding a long 1-byte transfer mid-way shows whether the count tracks the writes and freezes with them. Stopping while held and then restarting shows that the partial descriptor is dropped and the chain is walked again from its head.

// File: rtl/lldma_pkg.sv
package lldma_pkg;

   localparam int unsigned WORD_W      = 32;
   localparam int unsigned DESC_WORDS  = 6;
   // configuration word field positions
   localparam int unsigned SRC_IO_BIT  = 5;
   localparam int unsigned DST_IO_BIT  = 21;
   localparam int unsigned SRC_WID_LSB = 9;
   localparam int unsigned DST_WID_LSB = 25;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FREQ,
      ST_FWAIT,
      ST_RUN,
      ST_RWAIT,
      ST_WRITE,
      ST_PKG
   } chan_st_e;

   typedef struct packed {
      logic [WORD_W-1:0] cfg;
      logic [WORD_W-1:0] src;
      logic [WORD_W-1:0] dst;
      logic [WORD_W-1:0] cnt;
      logic [WORD_W-1:0] para;
      logic [WORD_W-1:0] nxt;
   } live_desc_t;

   // code 3 is treated as 4 bytes
   function automatic logic [1:0] norm_code(input logic [1:0] c);
      return (c == 2'd3) ? 2'd2 : c;
   endfunction

   function automatic logic [1:0] beat_code(input logic [1:0] s, input logic [1:0] d);
      logic [1:0] sn;
      logic [1:0] dn;
      sn = norm_code(s);
      dn = norm_code(d);
      return (sn < dn) ? sn : dn;
   endfunction

   function automatic logic [2:0] code_bytes(input logic [1:0] c);
      return 3'd1 << c;
   endfunction

endpackage

// File: rtl/lldma_step.sv
module lldma_step
   import lldma_pkg::*;
#(
   parameter int unsigned AW       = 32,
   parameter bit          ALLOW_IO = 1'b1
) (
   input  logic [AW-1:0] addr_i,
   input  logic          io_i,
   input  logic [1:0]    code_i,
   output logic [AW-1:0] next_o
);

   localparam int unsigned PAD_W = AW - 3;

   logic [AW-1:0] inc;
   assign inc = addr_i + {{PAD_W{1'b0}}, code_bytes(code_i)};

   generate
      if (AW < 8) begin : g_bad_aw
         $error("lldma_step: AW must be at least 8");
      end
      if (ALLOW_IO) begin : g_io
         assign next_o = io_i ? addr_i : inc;
      end else begin : g_lin
         logic unused_io;
         assign unused_io = io_i;
         assign next_o    = inc;
      end
   endgenerate

endmodule

// File: rtl/lldma_regs.sv
module lldma_regs
   import lldma_pkg::*;
#(
   parameter int unsigned      REG_AW   = 12,
   parameter logic [REG_AW-1:0] WIN_BASE = 12'h100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wen_i,
   input  logic [REG_AW-1:0] addr_i,
   input  logic [31:0]       wdata_i,
   output logic [31:0]       rdata_o,
   input  logic              busy_i,
   input  live_desc_t        live_i,
   output logic              start_o,
   output logic              stop_o,
   output logic              hold_o,
   output logic [31:0]       first_o
);

   localparam logic [5:0] OFF_EN    = 6'h00;
   localparam logic [5:0] OFF_HOLD  = 6'h04;
   localparam logic [5:0] OFF_FIRST = 6'h08;
   localparam logic [5:0] OFF_CFG   = 6'h0C;
   localparam logic [5:0] OFF_SRC   = 6'h10;
   localparam logic [5:0] OFF_DST   = 6'h14;
   localparam logic [5:0] OFF_CNT   = 6'h18;
   localparam logic [5:0] OFF_PARA  = 6'h1C;

   generate
      if (REG_AW < 7) begin : g_bad_aw
         $error("lldma_regs: REG_AW too small for a 64-byte window");
      end
      if (WIN_BASE[5:0] != 6'd0) begin : g_bad_base
         $error("lldma_regs: WIN_BASE must be 64-byte aligned");
      end
   endgenerate

   logic       hit;
   logic [5:0] off;
   logic       hold_q;
   logic [31:0] first_q;

   assign hit = (addr_i[REG_AW-1:6] == WIN_BASE[REG_AW-1:6]);
   assign off = addr_i[5:0];

   assign start_o = wen_i && hit && (off == OFF_EN) &&  wdata_i[0];
   assign stop_o  = wen_i && hit && (off == OFF_EN) && !wdata_i[0];
   assign hold_o  = hold_q;
   assign first_o = first_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q  <= 1'b0;
         first_q <= '0;
      end else begin
         if (stop_o) begin
            hold_q <= 1'b0;
         end else if (wen_i && hit && (off == OFF_HOLD)) begin
            hold_q <= wdata_i[1];
         end
         if (wen_i && hit && (off == OFF_FIRST)) begin
            first_q <= wdata_i;
         end
      end
   end

   always_comb begin
      rdata_o = '0;
      if (hit) begin
         case (off)
            OFF_EN:    rdata_o = {31'd0, busy_i};
            OFF_HOLD:  rdata_o = {30'd0, hold_q, 1'b0};
            OFF_FIRST: rdata_o = first_q;
            OFF_CFG:   rdata_o = live_i.cfg;
            OFF_SRC:   rdata_o = live_i.src;
            OFF_DST:   rdata_o = live_i.dst;
            OFF_CNT:   rdata_o = live_i.cnt;
            OFF_PARA:  rdata_o = live_i.para;
            default:   rdata_o = '0;
         endcase
      end
   end

   // R10
   stop_clears_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_o |=> !hold_q);

endmodule

// File: rtl/lldma_seq.sv
module lldma_seq
   import lldma_pkg::*;
#(
   parameter logic [31:0] END_MARK = 32'hFFFF_F800
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start_i,
   input  logic        stop_i,
   input  logic        hold_i,
   input  logic [31:0] first_i,
   output logic        desc_req_o,
   output logic [31:0] desc_addr_o,
   input  logic        desc_rvalid_i,
   input  logic [31:0] desc_rdata_i,
   output logic        rd_req_o,
   output logic [31:0] rd_addr_o,
   output logic [1:0]  rd_size_o,
   input  logic        rvalid_i,
   input  logic [31:0] rdata_i,
   output logic        wr_en_o,
   output logic [31:0] wr_addr_o,
   output logic [1:0]  wr_size_o,
   output logic [31:0] wr_data_o,
   input  logic        periph_ready_i,
   output logic        pkg_done_o,
   output logic        queue_done_o,
   output logic        busy_o,
   output live_desc_t  live_o
);

   localparam int unsigned IDX_W    = $clog2(DESC_WORDS);
   localparam int unsigned NPTR     = 2;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

   generate
      if (END_MARK[1:0] != 2'b00) begin : g_bad_end
         $error("lldma_seq: END_MARK must be word aligned");
      end
   endgenerate

   chan_st_e         st_q;
   logic [IDX_W-1:0] widx_q;
   logic [31:0]      dptr_q;
   live_desc_t       ld_q;
   logic [31:0]      buf_q;

   logic [1:0]  code;
   logic        src_io;
   logic        dst_io;
   logic        gate_ok;
   logic [31:0] step_w;
   logic [31:0] dec;
   logic [NPTR-1:0][31:0] ptr_cur;
   logic [NPTR-1:0][31:0] ptr_nxt;
   logic [NPTR-1:0]       ptr_io;

   assign code    = beat_code(ld_q.cfg[SRC_WID_LSB +: 2], ld_q.cfg[DST_WID_LSB +: 2]);
   assign src_io  = ld_q.cfg[SRC_IO_BIT];
   assign dst_io  = ld_q.cfg[DST_IO_BIT];
   assign gate_ok = !(src_io || dst_io) || periph_ready_i;
   assign step_w  = {29'd0, code_bytes(code)};
   assign dec     = (ld_q.cnt < step_w) ? ld_q.cnt : step_w;

   assign ptr_cur[0] = ld_q.src;
   assign ptr_cur[1] = ld_q.dst;
   assign ptr_io[0]  = src_io;
   assign ptr_io[1]  = dst_io;

   generate
      for (genvar g = 0; g < NPTR; g++) begin : g_ptr
         lldma_step #(.AW(32), .ALLOW_IO(1'b1)) u_step (
            .addr_i (ptr_cur[g]),
            .io_i   (ptr_io[g]),
            .code_i (code),
            .next_o (ptr_nxt[g])
         );
      end
   endgenerate

   assign desc_req_o   = (st_q == ST_FREQ) && !hold_i;
   assign desc_addr_o  = dptr_q + {{(30-IDX_W){1'b0}}, widx_q, 2'b00};
   assign rd_req_o     = (st_q == ST_RUN) && (ld_q.cnt != 32'd0) && !hold_i && gate_ok;
   assign rd_addr_o    = ld_q.src;
   assign rd_size_o    = code;
   assign wr_en_o      = (st_q == ST_WRITE);
   assign wr_addr_o    = ld_q.dst;
   assign wr_size_o    = code;
   assign wr_data_o    = buf_q;
   assign pkg_done_o   = (st_q == ST_PKG);
   assign queue_done_o = (st_q == ST_PKG) && (ld_q.nxt == END_MARK);
   assign busy_o       = (st_q != ST_IDLE);
   assign live_o       = ld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         widx_q <= '0;
         dptr_q <= '0;
         ld_q   <= '0;
         buf_q  <= '0;
      end else if (stop_i) begin
         st_q <= ST_IDLE;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (start_i) begin
                  dptr_q <= {first_i[31:2], 2'b00};
                  widx_q <= '0;
                  st_q   <= ST_FREQ;
               end
            end
            ST_FREQ: begin
               if (!hold_i) st_q <= ST_FWAIT;
            end
            ST_FWAIT: begin
               if (desc_rvalid_i) begin
                  case (widx_q)
                     IDX_W'(0): ld_q.cfg  <= desc_rdata_i;
                     IDX_W'(1): ld_q.src  <= desc_rdata_i;
                     IDX_W'(2): ld_q.dst  <= desc_rdata_i;
                     IDX_W'(3): ld_q.cnt  <= desc_rdata_i;
                     IDX_W'(4): ld_q.para <= desc_rdata_i;
                     default:   ld_q.nxt  <= desc_rdata_i;
                  endcase
                  if (widx_q == LAST_IDX) begin
                     st_q <= ST_RUN;
                  end else begin
                     widx_q <= widx_q + 1'b1;
                     st_q   <= ST_FREQ;
                  end
               end
            end
            ST_RUN: begin
               if (!hold_i && (ld_q.cnt == 32'd0)) begin
                  st_q <= ST_PKG;
               end else if (rd_req_o) begin
                  st_q <= ST_RWAIT;
               end
            end
            ST_RWAIT: begin
               if (rvalid_i) begin
                  buf_q <= rdata_i;
                  st_q  <= ST_WRITE;
               end
            end
            ST_WRITE: begin
               ld_q.src <= ptr_nxt[0];
               ld_q.dst <= ptr_nxt[1];
               ld_q.cnt <= ld_q.cnt - dec;
               st_q     <= ST_RUN;
            end
            ST_PKG: begin
               if (ld_q.nxt == END_MARK) begin
                  st_q <= ST_IDLE;
               end else begin
                  dptr_q <= {ld_q.nxt[31:2], 2'b00};
                  widx_q <= '0;
                  st_q   <= ST_FREQ;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   // R5
   one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({desc_req_o, rd_req_o, wr_en_o}) <= 1);

   // R7
   cnt_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_o && !stop_i) |=> (ld_q.cnt < $past(ld_q.cnt)));

   // R6
   dst_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_o && dst_io && !stop_i) |=> $stable(ld_q.dst));

   // R9
   hold_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == ST_RUN) && hold_i && !stop_i) |=> ($stable(ld_q.cnt) && $stable(ld_q.src)));

   // R11
   desc_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      desc_req_o |-> (desc_addr_o[1:0] == 2'b00));

   // R3
   end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (queue_done_o && !stop_i) |=> !busy_o);

   // R10
   stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_i |=> (!busy_o && !pkg_done_o && !wr_en_o));

endmodule

// File: rtl/lldma_chan.sv
module lldma_chan
   import lldma_pkg::*;
#(
   parameter int unsigned CHAN_IDX = 0,
   parameter int unsigned REG_AW   = 12,
   parameter logic [31:0] END_MARK = 32'hFFFF_F800
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wen,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              desc_req_o,
   output logic [31:0]       desc_addr_o,
   input  logic              desc_rvalid_i,
   input  logic [31:0]       desc_rdata_i,
   output logic              xfer_rd_req_o,
   output logic [31:0]       xfer_rd_addr_o,
   output logic [1:0]        xfer_rd_size_o,
   input  logic              xfer_rvalid_i,
   input  logic [31:0]       xfer_rdata_i,
   output logic              xfer_wr_en_o,
   output logic [31:0]       xfer_wr_addr_o,
   output logic [1:0]        xfer_wr_size_o,
   output logic [31:0]       xfer_wr_data_o,
   input  logic              periph_ready_i,
   output logic              pkg_done_o,
   output logic              queue_done_o
);

   localparam longint unsigned WIN_LO   = 64'h100 + 64'h40 * CHAN_IDX;
   localparam longint unsigned WIN_TOP  = WIN_LO + 64'h40;
   localparam longint unsigned SPACE    = 64'd1 << REG_AW;
   localparam logic [REG_AW-1:0] WIN_BASE = REG_AW'(WIN_LO);

   generate
      if (WIN_TOP > SPACE) begin : g_bad_win
         $error("lldma_chan: channel window does not fit in REG_AW");
      end
   endgenerate

   logic        start;
   logic        stop;
   logic        hold;
   logic [31:0] first;
   logic        busy;
   live_desc_t  live;

   lldma_regs #(.REG_AW(REG_AW), .WIN_BASE(WIN_BASE)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wen_i   (reg_wen),
      .addr_i  (reg_addr),
      .wdata_i (reg_wdata),
      .rdata_o (reg_rdata),
      .busy_i  (busy),
      .live_i  (live),
      .start_o (start),
      .stop_o  (stop),
      .hold_o  (hold),
      .first_o (first)
   );

   lldma_seq #(.END_MARK(END_MARK)) u_seq (
      .clk            (clk),
      .rst_n          (rst_n),
      .start_i        (start),
      .stop_i         (stop),
      .hold_i         (hold),
      .first_i        (first),
      .desc_req_o     (desc_req_o),
      .desc_addr_o    (desc_addr_o),
      .desc_rvalid_i  (desc_rvalid_i),
      .desc_rdata_i   (desc_rdata_i),
      .rd_req_o       (xfer_rd_req_o),
      .rd_addr_o      (xfer_rd_addr_o),
      .rd_size_o      (xfer_rd_size_o),
      .rvalid_i       (xfer_rvalid_i),
      .rdata_i        (xfer_rdata_i),
      .wr_en_o        (xfer_wr_en_o),
      .wr_addr_o      (xfer_wr_addr_o),
      .wr_size_o      (xfer_wr_size_o),
      .wr_data_o      (xfer_wr_data_o),
      .periph_ready_i (periph_ready_i),
      .pkg_done_o     (pkg_done_o),
      .queue_done_o   (queue_done_o),
      .busy_o         (busy),
      .live_o         (live)
   );

   // R4
   pkg_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pkg_done_o |=> !pkg_done_o);

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !(desc_req_o || xfer_rd_req_o || xfer_wr_en_o || pkg_done_o));

endmodule

// File: tb/lldma_chan_tb.sv
module lldma_chan_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int CHAN       = 1;
   localparam logic [11:0] WIN = 12'h100 + 12'h40 * CHAN;
   localparam logic [31:0] ENDM = 32'hFFFF_F800;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        reg_wen;
   logic [11:0] reg_addr;
   logic [31:0] reg_wdata;
   logic [31:0] reg_rdata;
   logic        desc_req;
   logic [31:0] desc_addr;
   logic        desc_rvalid;
   logic [31:0] desc_rdata;
   logic        rd_req;
   logic [31:0] rd_addr;
   logic [1:0]  rd_size;
   logic        rvalid;
   logic [31:0] rdata;
   logic        wr_en;
   logic [31:0] wr_addr;
   logic [1:0]  wr_size;
   logic [31:0] wr_data;
   logic        periph_ready;
   logic        pkg_done;
   logic        queue_done;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   int n_pkg = 0, n_queue = 0, n_rd = 0, n_wr = 0, n_dreq = 0, n_wr_off = 0;
   bit          watch_en = 1'b0;
   logic [31:0] watch_addr = '0;

   logic [7:0] mem [0:4095];

   always #(CLK_PERIOD/2) clk = ~clk;

   lldma_chan #(.CHAN_IDX(CHAN), .REG_AW(12)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .desc_req_o(desc_req), .desc_addr_o(desc_addr),
      .desc_rvalid_i(desc_rvalid), .desc_rdata_i(desc_rdata),
      .xfer_rd_req_o(rd_req), .xfer_rd_addr_o(rd_addr), .xfer_rd_size_o(rd_size),
      .xfer_rvalid_i(rvalid), .xfer_rdata_i(rdata),
      .xfer_wr_en_o(wr_en), .xfer_wr_addr_o(wr_addr), .xfer_wr_size_o(wr_size),
      .xfer_wr_data_o(wr_data),
      .periph_ready_i(periph_ready),
      .pkg_done_o(pkg_done), .queue_done_o(queue_done)
   );

   function automatic logic [31:0] get32(input logic [31:0] a);
      return {mem[(a+3) & 12'hFFF], mem[(a+2) & 12'hFFF], mem[(a+1) & 12'hFFF], mem[a & 12'hFFF]};
   endfunction

   // memory model and event monitor
   always @(posedge clk) begin
      if (!rst_n) begin
         desc_rvalid <= 1'b0;
         rvalid      <= 1'b0;
      end else begin
         desc_rvalid <= desc_req;
         desc_rdata  <= get32(desc_addr);
         rvalid      <= rd_req;
         rdata       <= get32(rd_addr);
         if (wr_en) begin
            for (int i = 0; i < (1 << wr_size); i++) begin
               mem[(wr_addr + i) & 12'hFFF] <= wr_data[8*i +: 8];
            end
            n_wr <= n_wr + 1;
            if (watch_en && wr_addr != watch_addr) n_wr_off <= n_wr_off + 1;
         end
         if (rd_req)     n_rd    <= n_rd + 1;
         if (desc_req)   n_dreq  <= n_dreq + 1;
         if (pkg_done)   n_pkg   <= n_pkg + 1;
         if (queue_done) n_queue <= n_queue + 1;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic put32(input logic [31:0] a, input logic [31:0] w);
      for (int i = 0; i < 4; i++) mem[(a + i) & 12'hFFF] = w[8*i +: 8];
   endtask

   task automatic put_desc(input logic [31:0] a, input logic [31:0] cfg, input logic [31:0] s,
                           input logic [31:0] d, input logic [31:0] len, input logic [31:0] para,
                           input logic [31:0] nxt);
      put32(a, cfg); put32(a + 4, s); put32(a + 8, d);
      put32(a + 12, len); put32(a + 16, para); put32(a + 20, nxt);
   endtask

   task automatic fill(input logic [31:0] a, input int n, input int seed);
      for (int i = 0; i < n; i++) mem[(a + i) & 12'hFFF] = 8'(seed + i * 5);
   endtask

   task automatic zero(input logic [31:0] a, input int n);
      for (int i = 0; i < n; i++) mem[(a + i) & 12'hFFF] = 8'h00;
   endtask

   function automatic int diff(input logic [31:0] s, input logic [31:0] d, input int n);
      int bad = 0;
      for (int i = 0; i < n; i++) if (mem[(s + i) & 12'hFFF] !== mem[(d + i) & 12'hFFF]) bad++;
      return bad;
   endfunction

   function automatic logic [31:0] mk_cfg(input int sw, input int dw, input bit sio, input bit dio);
      return (32'(sw) << 9) | (32'(dw) << 25) | (32'(sio) << 5) | (32'(dio) << 21);
   endfunction

   task automatic reg_write(input logic [5:0] off, input logic [31:0] d);
      @(negedge clk);
      reg_wen = 1'b1; reg_addr = WIN + {6'd0, off}; reg_wdata = d;
      @(negedge clk);
      reg_wen = 1'b0;
   endtask

   task automatic reg_read(input logic [5:0] off, output logic [31:0] d);
      @(negedge clk);
      reg_addr = WIN + {6'd0, off};
      #1;
      d = reg_rdata;
   endtask

   task automatic wait_idle(input string tag);
      logic [31:0] v;
      v = 32'd1;
      for (int k = 0; k < 3000; k++) begin
         reg_read(6'h00, v);
         if (!v[0]) break;
      end
      chk({tag, " channel returns idle"}, v[0], 1'b0);
   endtask

   task automatic idle_cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      logic [31:0] v;
      reg_read(6'h00, v); chk("R1 enable after reset", v, 0);
      reg_read(6'h04, v); chk("R1 hold after reset", v, 0);
      reg_read(6'h18, v); chk("R1 count after reset", v, 0);
      idle_cycles(10);
      chk("R1 no requests or events", n_dreq + n_rd + n_wr + n_pkg, 0);
   endtask

   task automatic t_single;
      logic [31:0] v;
      int p0, q0, w0, d0;
      fill(32'h400, 16, 3); zero(32'h800, 16);
      put_desc(32'h040, mk_cfg(2, 2, 0, 0), 32'h400, 32'h800, 16, 32'h8, ENDM);
      p0 = n_pkg; q0 = n_queue; w0 = n_wr; d0 = n_dreq;
      reg_write(6'h08, 32'h040);
      reg_write(6'h00, 32'h1);
      wait_idle("R3 single");
      chk("R5 single copy mismatches", diff(32'h400, 32'h800, 16), 0);
      chk("R5 four-byte beats", n_wr - w0, 4);
      chk("R2 six descriptor words fetched", n_dreq - d0, 6);
      chk("R4 one package event", n_pkg - p0, 1);
      chk("R3 one queue event", n_queue - q0, 1);
      reg_read(6'h0C, v); chk("R2 config readback", v, mk_cfg(2, 2, 0, 0));
      reg_read(6'h1C, v); chk("R2 parameter readback", v, 32'h8);
      reg_read(6'h10, v); chk("R6 source advanced", v, 32'h410);
      reg_read(6'h14, v); chk("R6 destination advanced", v, 32'h810);
      reg_read(6'h18, v); chk("R7 count drained", v, 0);
   endtask

   task automatic t_chain;
      int p0, q0, w0, d0;
      fill(32'h480, 5, 40); zero(32'h880, 5);
      fill(32'h4A0, 6, 90); zero(32'h8A0, 6);
      put_desc(32'h100, mk_cfg(0, 0, 0, 0), 32'h480, 32'h880, 5, 0, 32'h123);
      put_desc(32'h120, mk_cfg(2, 1, 0, 0), 32'h4A0, 32'h8A0, 6, 0, ENDM);
      p0 = n_pkg; q0 = n_queue; w0 = n_wr; d0 = n_dreq;
      reg_write(6'h08, 32'h102);
      reg_write(6'h00, 32'h1);
      wait_idle("R4 chain");
      chk("R5 byte descriptor copied", diff(32'h480, 32'h880, 5), 0);
      chk("R11 misaligned next pointer followed", diff(32'h4A0, 32'h8A0, 6), 0);
      chk("R5 beats 5 byte plus 3 halfword", n_wr - w0, 8);
      chk("R4 two package events", n_pkg - p0, 2);
      chk("R3 single queue event", n_queue - q0, 1);
      chk("R2 twelve descriptor words", n_dreq - d0, 12);
   endtask

   task automatic t_fixed_dst;
      logic [31:0] v;
      int r0, q0;
      fill(32'h500, 16, 17); put32(32'hC00, 32'h0);
      put_desc(32'h180, mk_cfg(2, 2, 0, 1), 32'h500, 32'hC00, 16, 0, ENDM);
      periph_ready = 1'b0;
      r0 = n_rd; q0 = n_queue;
      watch_addr = 32'hC00; watch_en = 1'b1;
      reg_write(6'h08, 32'h180);
      reg_write(6'h00, 32'h1);
      idle_cycles(30);
      chk("R8 no read while not ready", n_rd - r0, 0);
      reg_read(6'h18, v); chk("R8 count untouched while not ready", v, 16);
      periph_ready = 1'b1;
      wait_idle("R8 fixed dst");
      watch_en = 1'b0;
      chk("R6 every write at fixed address", n_wr_off, 0);
      chk("R6 fixed address holds last word", get32(32'hC00), get32(32'h50C));
      reg_read(6'h14, v); chk("R6 destination readback fixed", v, 32'hC00);
      reg_read(6'h10, v); chk("R6 source linear", v, 32'h510);
      chk("R3 queue event fixed dst", n_queue - q0, 1);
   endtask

   task automatic t_hold;
      logic [31:0] c1, c2, v;
      int w0, w1, q0;
      fill(32'h600, 64, 7); zero(32'hD00, 64);
      put_desc(32'h1C0, mk_cfg(0, 0, 0, 0), 32'h600, 32'hD00, 64, 0, ENDM);
      q0 = n_queue; w0 = n_wr;
      reg_write(6'h08, 32'h1C0);
      reg_write(6'h00, 32'h1);
      for (int k = 0; k < 500; k++) begin
         @(negedge clk);
         if (n_wr - w0 >= 10) break;
      end
      reg_write(6'h04, 32'h2);
      idle_cycles(4);
      reg_read(6'h18, c1);
      w1 = n_wr;
      chk("R7 count equals length minus written", c1, 32'(64 - (w1 - w0)));
      idle_cycles(30);
      reg_read(6'h18, c2);
      chk("R9 count frozen while held", c2, c1);
      chk("R9 no writes while held", n_wr - w1, 0);
      reg_read(6'h04, v); chk("R9 hold readback", v, 32'h2);
      reg_write(6'h04, 32'h0);
      wait_idle("R9 resume");
      chk("R9 copy complete after resume", diff(32'h600, 32'hD00, 64), 0);
      chk("R9 queue event after resume", n_queue - q0, 1);
   endtask

   task automatic t_stop;
      logic [31:0] c1, v;
      int w0, w1, p1, q1;
      zero(32'hE00, 64);
      put_desc(32'h200, mk_cfg(0, 0, 0, 0), 32'h600, 32'hE00, 64, 0, ENDM);
      w0 = n_wr;
      reg_write(6'h08, 32'h200);
      reg_write(6'h00, 32'h1);
      for (int k = 0; k < 500; k++) begin
         @(negedge clk);
         if (n_wr - w0 >= 8) break;
      end
      reg_write(6'h04, 32'h2);
      idle_cycles(4);
      reg_read(6'h18, c1);
      reg_write(6'h00, 32'h0);
      w1 = n_wr; p1 = n_pkg; q1 = n_queue;
      idle_cycles(30);
      reg_read(6'h00, v); chk("R10 enable reads idle after stop", v, 0);
      reg_read(6'h04, v); chk("R10 hold cleared by stop", v, 0);
      reg_read(6'h18, v); chk("R10 partial count left as stopped", v, c1);
      chk("R10 no writes after stop", n_wr - w1, 0);
      chk("R10 no events after stop", (n_pkg - p1) + (n_queue - q1), 0);
      reg_write(6'h00, 32'h1);
      wait_idle("R10 restart");
      chk("R10 restart copies whole chain", diff(32'h600, 32'hE00, 64), 0);
      chk("R10 restart queue event", n_queue - q1, 1);
   endtask

   task automatic t_zero_len;
      int p0, q0, w0, r0;
      put_desc(32'h240, mk_cfg(2, 2, 0, 0), 32'h400, 32'hF00, 0, 0, ENDM);
      p0 = n_pkg; q0 = n_queue; w0 = n_wr; r0 = n_rd;
      reg_write(6'h08, 32'h240);
      reg_write(6'h00, 32'h1);
      wait_idle("R12 zero length");
      chk("R12 package event for empty descriptor", n_pkg - p0, 1);
      chk("R12 queue event for empty descriptor", n_queue - q0, 1);
      chk("R12 no data moved", (n_wr - w0) + (n_rd - r0), 0);
   endtask

   initial begin
      rst_n = 1'b0; reg_wen = 1'b0; reg_addr = '0; reg_wdata = '0; periph_ready = 1'b1;
      for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
      idle_cycles(5);
      rst_n = 1'b1;
      t_reset();
      t_single();
      t_chain();
      t_fixed_dst();
      t_hold();
      t_stop();
      t_zero_len();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual running expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule